// File: doc/BRIEF.md
# Address Register Adjust Unit

This block keeps four address pointers and four index offsets for a signal-processing core and carries out the short instructions that move those pointers. Each cycle it may accept one 16-bit instruction word. When the word is one of the adjust forms, the block steps the selected pointer by one in either direction, or moves it by a signed index offset in either direction. It then reports a decode hit for that cycle. Any other word is ignored and the hit is low.

The pointer update is ordinary modular arithmetic on the pointer width: results wrap, and nothing saturates or raises a flag. Offsets are loaded through a separate write port. Any pointer can be read back through a combinational read port. The instruction input has a valid strobe and no ready signal: every valid word is taken in the cycle it is presented, so the block never applies back-pressure.

Top module: `addr_adjust_unit`

## Requirements
- R1: After reset, all four pointers and all four offsets are zero.
- R2: The word 0x0004 + d (d = 0..3, in bits 1:0) lowers pointer d by one. The new value is visible on the read port in the cycle after the word is accepted.
- R3: The word 0x0008 + d raises pointer d by one, with the same one-cycle latency.
- R4: The word 0x000C + d subtracts offset d from pointer d. The offset always belongs to the same pointer number.
- R5: The word 0x0010 + 4*s + d (s in bits 3:2, d in bits 1:0) adds offset s to pointer d. The offset is taken as a signed two's-complement value.
- R6: All pointer results wrap modulo 2^16. For example, 0xFFFF + 1 = 0x0000, 0x0000 - 1 = 0xFFFF and 0x0001 + 0xFFFE = 0xFFFF.
- R7: A valid word that matches none of the forms above (for example 0x0000 to 0x0003, 0x0020 or 0x1C1F) changes no pointer, and op_hit stays low.
- R8: op_hit is high, in the same cycle, exactly when op_valid is high and op_code is a matching form. While op_valid is low, op_code has no effect.
- R9: With idx_wr_en high, offset idx_wr_sel takes idx_wr_data at the clock edge. An instruction in a later cycle uses the new offset.
- R10: When an offset is written in the same cycle as an instruction that uses that offset, the instruction uses the value held before the write.
- R11: An accepted instruction changes only the pointer it selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Instruction word present this cycle |
| op_code | input | 16 | Instruction word |
| op_hit | output | 1 | Word is valid and is one of the adjust forms |
| idx_wr_en | input | 1 | Offset write strobe |
| idx_wr_sel | input | 2 | Offset number to write |
| idx_wr_data | input | 16 | Offset value to write |
| rd_sel | input | 2 | Pointer number to read |
| rd_data | output | 16 | Value of the selected pointer |

## Verification
An offset write and an offset-using instruction can fall in the same cycle, which makes the offset load and the pointer update collide. The bench provokes this by writing offset 0 while a subtract on pointer 0 is presented in the same cycle. The pointer must then have moved by the old offset. A second subtract in a following cycle must move it by the new offset. Both results are compared with values worked out by hand from the requirements.

// File: rtl/aau_pkg.sv
package aau_pkg;
  localparam int OPC_W  = 16;
  localparam int NREG   = 4;
  localparam int SEL_W  = $clog2(NREG);

  typedef enum logic [2:0] {
    OP_NONE,
    OP_DEC,
    OP_INC,
    OP_SUB,
    OP_ADD
  } aau_op_e;
endpackage

// File: rtl/aau_decoder.sv
module aau_decoder
  import aau_pkg::*;
(
  input  logic             op_valid,
  input  logic [OPC_W-1:0] op_code,
  output aau_op_e          kind,
  output logic [SEL_W-1:0] dst,
  output logic [SEL_W-1:0] src,
  output logic             hit
);
  always_comb begin
    kind = OP_NONE;
    dst  = op_code[1:0];
    src  = op_code[1:0];
    if (op_valid) begin
      if (op_code[15:4] == 12'h000) begin
        unique case (op_code[3:2])
          2'b01:   kind = OP_DEC;
          2'b10:   kind = OP_INC;
          2'b11:   kind = OP_SUB;
          default: kind = OP_NONE;
        endcase
      end else if (op_code[15:5] == 11'h000) begin
        kind = OP_ADD;
        src  = op_code[3:2];
      end
    end
    hit = (kind != OP_NONE);
  end
endmodule

// File: rtl/aau_index_file.sv
module aau_index_file
  import aau_pkg::*;
#(
  parameter int IDX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [IDX_W-1:0] wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [IDX_W-1:0] rd_data
);
  logic [IDX_W-1:0] ix_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_ix
    always_ff @(posedge clk) begin
      if (!rst_n)                       ix_q[i] <= '0;
      else if (wr_en && wr_sel == i)    ix_q[i] <= wr_data;
    end
  end

  // Read returns the value held before any write in this cycle (R10)
  assign rd_data = ix_q[rd_sel];

  // R9: a write lands in the selected offset at the next edge
  a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ix_q[$past(wr_sel)] == $past(wr_data));
endmodule

// File: rtl/aau_addr_file.sv
module aau_addr_file
  import aau_pkg::*;
#(
  parameter int AW    = 16,
  parameter int IDX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  aau_op_e          upd_kind,
  input  logic [SEL_W-1:0] upd_dst,
  input  logic [IDX_W-1:0] idx_val,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [AW-1:0]    rd_data
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0]       ar_q [NREG];
  logic [AW+IDX_W-1:0] ext_full;
  logic [AW-1:0]       idx_ext;
  logic [AW-1:0]       cur;
  logic [AW-1:0]       nxt;

  // Sign-extend the offset to the pointer width
  assign ext_full = {{AW{idx_val[IDX_W-1]}}, idx_val};
  assign idx_ext  = ext_full[AW-1:0];
  assign cur      = ar_q[upd_dst];

  always_comb begin
    unique case (upd_kind)
      OP_DEC:  nxt = cur - ONE;
      OP_INC:  nxt = cur + ONE;
      OP_SUB:  nxt = cur - idx_ext;
      OP_ADD:  nxt = cur + idx_ext;
      default: nxt = cur;
    endcase
  end

  for (genvar i = 0; i < NREG; i++) begin : g_ar
    always_ff @(posedge clk) begin
      if (!rst_n)
        ar_q[i] <= '0;
      else if (upd_kind != OP_NONE && upd_dst == i)
        ar_q[i] <= nxt;
    end

    // R11 and R7: any pointer not targeted this cycle holds its value
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(upd_kind != OP_NONE && upd_dst == i) |=> ar_q[i] == $past(ar_q[i]));
  end

  assign rd_data = ar_q[rd_sel];

  a_r2_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_kind == OP_DEC) |=> ar_q[$past(upd_dst)] == $past(cur) - ONE);

  a_r3_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_kind == OP_INC) |=> ar_q[$past(upd_dst)] == $past(cur) + ONE);

  a_r5_add: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_kind == OP_ADD) |=> ar_q[$past(upd_dst)] == $past(cur) + $past(idx_ext));
endmodule

// File: rtl/addr_adjust_unit.sv
module addr_adjust_unit
  import aau_pkg::*;
#(
  parameter int AW    = 16,
  parameter int IDX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [15:0]      op_code,
  output logic             op_hit,
  input  logic             idx_wr_en,
  input  logic [1:0]       idx_wr_sel,
  input  logic [IDX_W-1:0] idx_wr_data,
  input  logic [1:0]       rd_sel,
  output logic [AW-1:0]    rd_data
);
  aau_op_e          kind;
  logic [SEL_W-1:0] dst;
  logic [SEL_W-1:0] src;
  logic [IDX_W-1:0] idx_val;

  aau_decoder u_dec (
    .op_valid (op_valid),
    .op_code  (op_code),
    .kind     (kind),
    .dst      (dst),
    .src      (src),
    .hit      (op_hit)
  );

  aau_index_file #(.IDX_W(IDX_W)) u_ix (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (idx_wr_en),
    .wr_sel  (idx_wr_sel),
    .wr_data (idx_wr_data),
    .rd_sel  (src),
    .rd_data (idx_val)
  );

  aau_addr_file #(.AW(AW), .IDX_W(IDX_W)) u_ar (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_kind (kind),
    .upd_dst  (dst),
    .idx_val  (idx_val),
    .rd_sel   (rd_sel),
    .rd_data  (rd_data)
  );

  // R8: no hit without a valid word
  a_r8_idle_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> !op_hit);
endmodule

// File: tb/addr_adjust_unit_tb.sv
module addr_adjust_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [15:0] op_code = '0;
  logic        op_hit;
  logic        idx_wr_en = 1'b0;
  logic [1:0]  idx_wr_sel = '0;
  logic [15:0] idx_wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [15:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  addr_adjust_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_hit(op_hit), .idx_wr_en(idx_wr_en), .idx_wr_sel(idx_wr_sel),
    .idx_wr_data(idx_wr_data), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  // {opcode, expected hit, pointer to read, expected pointer value}
  localparam int NV = 16;
  localparam logic [34:0] VEC [NV] = '{
    {16'h0008, 1'b1, 2'd0, 16'h0001},  // R3 inc p0
    {16'h0005, 1'b1, 2'd1, 16'hFFFF},  // R2/R6 dec p1 wraps
    {16'h0009, 1'b1, 2'd1, 16'h0000},  // R3/R6 inc p1 wraps
    {16'h000E, 1'b1, 2'd2, 16'h8000},  // R4 p2 - ix2
    {16'h0012, 1'b1, 2'd2, 16'h8003},  // R5 p2 + ix0
    {16'h0014, 1'b1, 2'd0, 16'hFFFF},  // R5/R6 p0 + ix1 (-2)
    {16'h001F, 1'b1, 2'd3, 16'h0100},  // R5 p3 + ix3
    {16'h000F, 1'b1, 2'd3, 16'h0000},  // R4 p3 - ix3
    {16'h0019, 1'b1, 2'd1, 16'h8000},  // R5 p1 + ix2
    {16'h0000, 1'b0, 2'd0, 16'hFFFF},  // R7 miss
    {16'h0003, 1'b0, 2'd3, 16'h0000},  // R7 miss
    {16'h0020, 1'b0, 2'd1, 16'h8000},  // R7 miss
    {16'h1C1F, 1'b0, 2'd2, 16'h8003},  // R7 miss
    {16'h0008, 1'b1, 2'd0, 16'h0000},  // R6 inc p0 wraps
    {16'h0017, 1'b1, 2'd3, 16'hFFFE},  // R5 p3 + ix1
    {16'h000D, 1'b1, 2'd1, 16'h8002}   // R4/R6 p1 - ix1
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_ptr(input logic [1:0] sel, input string req, input logic [15:0] exp);
    rd_sel = sel;
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic run_op(input logic [15:0] op, input string req, input logic exp_hit);
    @(negedge clk);
    op_valid = 1'b1;
    op_code  = op;
    #1;
    chk(req, {15'd0, op_hit}, {15'd0, exp_hit});
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic load_ix(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    idx_wr_en = 1'b1; idx_wr_sel = sel; idx_wr_data = val;
    @(negedge clk);
    idx_wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: pointers zero after reset
    for (int i = 0; i < 4; i++) read_ptr(i[1:0], "R1 pointer", 16'h0000);
    // R1: offset 0 is zero, so subtract leaves p0 at zero
    run_op(16'h000C, "R1 hit", 1'b1);
    read_ptr(2'd0, "R1 offset zero", 16'h0000);

    // R9: load offsets for the table
    load_ix(2'd0, 16'h0003);
    load_ix(2'd1, 16'hFFFE);
    load_ix(2'd2, 16'h8000);
    load_ix(2'd3, 16'h0100);

    for (int v = 0; v < NV; v++) begin
      run_op(VEC[v][34:19], "R2-R7 table hit", VEC[v][18]);
      read_ptr(VEC[v][17:16], $sformatf("table row %0d value", v), VEC[v][15:0]);
    end

    // R11: all pointers hold their expected values; a p2 update leaves others alone
    run_op(16'h000A, "R11 hit", 1'b1);
    read_ptr(2'd2, "R11 target", 16'h8004);
    read_ptr(2'd0, "R11 p0 held", 16'h0000);
    read_ptr(2'd1, "R11 p1 held", 16'h8002);
    read_ptr(2'd3, "R11 p3 held", 16'hFFFE);

    // R8: word ignored while op_valid is low
    @(negedge clk);
    op_valid = 1'b0; op_code = 16'h0008;
    #1;
    chk("R8 idle hit", {15'd0, op_hit}, 16'h0000);
    @(negedge clk);
    read_ptr(2'd0, "R8 idle no change", 16'h0000);

    // R10: offset write and subtract in the same cycle use the old offset (3)
    @(negedge clk);
    idx_wr_en = 1'b1; idx_wr_sel = 2'd0; idx_wr_data = 16'h0010;
    op_valid = 1'b1; op_code = 16'h000C;
    @(negedge clk);
    idx_wr_en = 1'b0; op_valid = 1'b0;
    read_ptr(2'd0, "R10 old offset", 16'hFFFD);
    // R9: next use sees the new offset
    run_op(16'h000C, "R9 hit", 1'b1);
    read_ptr(2'd0, "R9 new offset", 16'hFFED);

    finish_run();
  end
endmodule